// File: doc/BRIEF.md
# SD Single-Block Write Data Serializer

This block sends one data block on DAT0 of an SD card running a 1-bit bus. It runs after the card has accepted the single-block write command. A pulse on `start` arms the block. Payload words then arrive on a valid/ready stream. Each word is 128 bits wide and holds 16 bytes. The block shifts the words out serially as a start bit, the payload most significant bit first, a CRC16 computed on the fly, and a stop bit. It then releases the line. After that it samples the card's status token and waits out the card's busy period. It finishes with a one-cycle `done` and a held verdict.

Every step advances on `tick`, a one-cycle strobe from the SD clock divider. The strobe marks the falling edge of the SD clock. New bits therefore appear on the line half a period before the card samples them on the rising edge. `dat0_in` is also sampled on the strobe.

The word stream accepts a beat when `word_valid` and `word_ready` are both high at a clock edge. The block holds one word being shifted and one spare word. It raises `word_ready` only while the spare slot is empty and the block still needs more words. Upstream may hold `word_valid` low at any time. If no bit is staged when a strobe comes, the serializer holds the line and does not advance.

Top module: `sd_blk_writer`

## Requirements
- R1: After `start`, the first strobe that finds a word staged drives the line (`dat0_oe`=1) with `dat0_out`=0 for exactly one strobe. Before that strobe `dat0_oe` stays 0, however long the stream withholds data.
- R2: The next 8*BLOCK_BYTES strobes carry the payload. Words go out in arrival order. Within a word, bit 127 goes first and bit 0 goes last. Byte 0 therefore sits in bits 127:120 and every byte goes out MSB first.
- R3: The 16 strobes after the last data bit carry a CRC16 of the data bits, MSB first. The CRC uses polynomial x^16+x^12+x^5+1 (0x1021) and an initial value of 0.
- R4: The next strobe drives `dat0_out`=1 as the stop bit, with `dat0_oe` still 1.
- R5: From the strobe after the stop bit, `dat0_oe` is 0 until the block is re-armed. The first two strobes after the stop bit are not sampled. Sampling of `dat0_in` starts at the third strobe.
- R6: The status token is a 0 start bit, three status bits (first received is MSB) and an end bit. Status 010 with end bit 1 gives `ok`. Any other token gives `crc_err`.
- R7: After the end bit, each strobe samples `dat0_in`. The strobe that first sees 1 ends the write, and `done` pulses high for exactly one clock.
- R8: REPLY_LIMIT consecutive high samples before the token start bit end the write with `timeout`=1 and `ok`=`crc_err`=0. REPLY_LIMIT low samples in the busy wait end it with `timeout`=1 and `ok`=0.
- R9: `dat0_out` and `dat0_oe` change only on clocks where `tick` is high.
- R10: `word_ready` is high only while the block is active. Exactly BLOCK_BYTES/WORD_BYTES words are accepted per block, and `word_ready` is 0 by the time `done` pulses.
- R11: `busy` is high from the clock after `start` until after `done`. A `start` while busy has no effect on the frame. `ok`, `crc_err` and `timeout` hold their values until the next accepted `start` clears them. After reset: `dat0_oe`=0, `dat0_out`=1, `word_ready`=0, `busy`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe at each SD clock falling edge |
| start | input | 1 | Arm pulse, taken only while idle |
| word_data | input | 8*WORD_BYTES | Payload word; byte 0 in the top bits |
| word_valid | input | 1 | Payload word present |
| word_ready | output | 1 | Block can take a payload word |
| dat0_out | output | 1 | Value driven on DAT0 |
| dat0_oe | output | 1 | DAT0 drive enable |
| dat0_in | input | 1 | DAT0 as seen on the pin |
| busy | output | 1 | Block is armed or working |
| done | output | 1 | One-cycle end-of-write pulse |
| ok | output | 1 | Card accepted the block and left busy |
| crc_err | output | 1 | Token other than accepted |
| timeout | output | 1 | Reply wait limit reached |

## Verification
The frame is driven with five payload patterns: all zeros, all ones, a byte counter, a scrambled counter and a constant XOR counter. The zero pattern gives a zero CRC. The others separate bit order inside a byte, byte order inside a word and word order. Strobe gaps of zero, one and two idle clocks show that the block moves only on the strobe. A held-off first word shows that the start bit waits for data. The replies cover an accepted token, a CRC-error token and a bad end bit. They also cover token lead and busy lengths on both sides of the limit, one below the limit and exactly at it, so each timeout edge and the `done` strobe position are pinned down.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
  localparam logic [15:0] CRC_POLY = 16'h1021;

  typedef enum logic [2:0] {
    TX_IDLE, TX_LEAD, TX_DATA, TX_CRC, TX_STOP, TX_REPLY
  } tx_state_t;

  typedef enum logic [2:0] {
    RX_OFF, RX_TURN, RX_WAIT, RX_STAT, RX_ENDB, RX_BUSY
  } rx_state_t;
endpackage

// File: rtl/sdw_stager.sv
module sdw_stager #(
  parameter int WORD_W = 128,
  parameter int WORDS  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [WORD_W-1:0] word_data,
  input  logic              word_valid,
  output logic              word_ready,
  input  logic              take,
  output logic              bit_avail,
  output logic              bit_val
);
  localparam int IW = $clog2(WORD_W);
  localparam int CW = $clog2(WORDS + 1);
  localparam logic [IW-1:0] IMAX = IW'(WORD_W - 1);

  logic [WORD_W-1:0] cur, nxt;
  logic              cur_vld, nxt_full;
  logic [IW-1:0]     idx;
  logic [CW-1:0]     left;
  logic              acc, last, cur_free;

  assign word_ready = (left != '0) && !nxt_full;
  assign acc        = word_valid && word_ready;
  assign last       = take && (idx == '0);
  assign cur_free   = !cur_vld || last;
  assign bit_avail  = cur_vld;
  assign bit_val    = cur[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur      <= '0;
      nxt      <= '0;
      cur_vld  <= 1'b0;
      nxt_full <= 1'b0;
      idx      <= IMAX;
      left     <= '0;
    end else if (flush) begin
      cur_vld  <= 1'b0;
      nxt_full <= 1'b0;
      idx      <= IMAX;
      left     <= CW'(WORDS);
    end else begin
      if (acc) left <= left - 1'b1;
      if (take) idx <= last ? IMAX : idx - 1'b1;
      if (cur_free) begin
        if (nxt_full) begin
          cur      <= nxt;
          cur_vld  <= 1'b1;
          nxt_full <= acc;
          if (acc) nxt <= word_data;
        end else if (acc) begin
          cur     <= word_data;
          cur_vld <= 1'b1;
        end else begin
          cur_vld <= 1'b0;
        end
      end else if (acc) begin
        nxt      <= word_data;
        nxt_full <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdw_crc16.sv
module sdw_crc16
  import sdw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic din,
  input  logic shift,
  output logic msb
);
  logic [15:0] crc;
  logic        fb;

  assign fb  = din ^ crc[15];
  assign msb = crc[15];

  always_ff @(posedge clk) begin
    if (!rst_n || clr)
      crc <= '0;
    else if (en)
      crc <= {crc[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    else if (shift)
      crc <= {crc[14:0], 1'b0};
  end
endmodule

// File: rtl/sdw_reply.sv
module sdw_reply
  import sdw_pkg::*;
#(
  parameter int LIMIT = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic arm,
  input  logic tick,
  input  logic din,
  output logic fin,
  output logic ok,
  output logic crc_err,
  output logic timeout
);
  localparam int TW = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] CMAX = TW'(LIMIT - 1);

  rx_state_t     ph;
  logic [TW-1:0] cnt;
  logic [2:0]    tok;
  logic [1:0]    sc;
  logic          tok_good;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= RX_OFF; cnt <= '0; tok <= '0; sc <= '0;
      tok_good <= 1'b0; fin <= 1'b0;
      ok <= 1'b0; crc_err <= 1'b0; timeout <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (clr) begin
        ok <= 1'b0; crc_err <= 1'b0; timeout <= 1'b0;
      end
      if (arm) begin
        ph  <= RX_TURN;
        cnt <= '0;
      end else if (tick) begin
        case (ph)
          RX_TURN: begin
            if (cnt == TW'(1)) begin ph <= RX_WAIT; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          end
          RX_WAIT: begin
            if (!din) begin
              ph <= RX_STAT; sc <= '0;
            end else if (cnt == CMAX) begin
              ph <= RX_OFF; fin <= 1'b1; timeout <= 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          RX_STAT: begin
            tok <= {tok[1:0], din};
            sc  <= sc + 1'b1;
            if (sc == 2'd2) ph <= RX_ENDB;
          end
          RX_ENDB: begin
            tok_good <= (tok == 3'b010) && din;
            crc_err  <= !((tok == 3'b010) && din);
            ph       <= RX_BUSY;
            cnt      <= '0;
          end
          RX_BUSY: begin
            if (din) begin
              ph <= RX_OFF; fin <= 1'b1; ok <= tok_good;
            end else if (cnt == CMAX) begin
              ph <= RX_OFF; fin <= 1'b1; timeout <= 1'b1; ok <= 1'b0;
            end else cnt <= cnt + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sd_blk_writer.sv
module sd_blk_writer
  import sdw_pkg::*;
#(
  parameter int BLOCK_BYTES = 512,
  parameter int WORD_BYTES  = 16,
  parameter int REPLY_LIMIT = 1000000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    start,
  input  logic [WORD_BYTES*8-1:0] word_data,
  input  logic                    word_valid,
  output logic                    word_ready,
  output logic                    dat0_out,
  output logic                    dat0_oe,
  input  logic                    dat0_in,
  output logic                    busy,
  output logic                    done,
  output logic                    ok,
  output logic                    crc_err,
  output logic                    timeout
);
  localparam int WORD_W = WORD_BYTES * 8;
  localparam int WORDS  = BLOCK_BYTES / WORD_BYTES;
  localparam int DBITS  = BLOCK_BYTES * 8;
  localparam int CW     = $clog2(DBITS);

  tx_state_t     st;
  logic [CW-1:0] cnt;
  logic          flush, take, bit_avail, bit_val;
  logic          crc_msb, crc_shift, arm, fin;

  assign busy      = (st != TX_IDLE);
  assign flush     = (st == TX_IDLE) && start;
  assign take      = (st == TX_DATA) && tick && bit_avail;
  assign crc_shift = (st == TX_CRC) && tick;
  assign arm       = (st == TX_STOP) && tick;

  sdw_stager #(.WORD_W(WORD_W), .WORDS(WORDS)) u_stage (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .word_data(word_data), .word_valid(word_valid), .word_ready(word_ready),
    .take(take), .bit_avail(bit_avail), .bit_val(bit_val)
  );

  sdw_crc16 u_crc (
    .clk(clk), .rst_n(rst_n), .clr(flush), .en(take), .din(bit_val),
    .shift(crc_shift), .msb(crc_msb)
  );

  sdw_reply #(.LIMIT(REPLY_LIMIT)) u_reply (
    .clk(clk), .rst_n(rst_n), .clr(flush), .arm(arm), .tick(tick),
    .din(dat0_in), .fin(fin), .ok(ok), .crc_err(crc_err), .timeout(timeout)
  );

  assign done = fin;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= TX_IDLE; dat0_out <= 1'b1; dat0_oe <= 1'b0; cnt <= '0;
    end else begin
      case (st)
        TX_IDLE: if (start) st <= TX_LEAD;
        TX_LEAD: if (tick && bit_avail) begin
          dat0_out <= 1'b0; dat0_oe <= 1'b1; st <= TX_DATA; cnt <= '0;
        end
        TX_DATA: if (take) begin
          dat0_out <= bit_val;
          if (cnt == CW'(DBITS - 1)) begin st <= TX_CRC; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        TX_CRC: if (tick) begin
          dat0_out <= crc_msb;
          if (cnt == CW'(15)) begin st <= TX_STOP; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        TX_STOP: if (tick) begin
          dat0_out <= 1'b1; st <= TX_REPLY;
        end
        TX_REPLY: begin
          if (tick) begin dat0_oe <= 1'b0; dat0_out <= 1'b1; end
          if (fin) st <= TX_IDLE;
        end
        default: st <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdw_checker.sv
module sdw_checker (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic word_ready,
  input logic dat0_out,
  input logic dat0_oe,
  input logic busy,
  input logic done,
  input logic ok,
  input logic crc_err,
  input logic timeout
);
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dat0_oe) |-> !dat0_out); // R1
  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dat0_oe) |-> $past(dat0_out)); // R4
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !dat0_oe); // R5
  AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(ok && crc_err) && !(ok && timeout)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_STROBE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(dat0_out) && $stable(dat0_oe))); // R9
  AST_READY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready |-> busy); // R10
  AST_DONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy); // R11
endmodule

bind sd_blk_writer sdw_checker u_chk (.*);

// File: tb/tb_sd_blk_writer.sv
`timescale 1ns/1ps
module tb_sd_blk_writer;
  localparam int BB = 32, WB = 16, NW = BB / WB, LIM = 20, DB = BB * 8, WW = WB * 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, tick = 1'b0, start = 1'b0, dat0_in = 1'b1;
  logic [WW-1:0] word_data;
  logic word_valid, word_ready, dat0_out, dat0_oe, busy, done, ok, crc_err, timeout;

  logic [WW-1:0] words [NW];
  int   widx;
  logic feed_on = 1'b0, feed_clr = 1'b0;
  int   n_chk = 0, n_bad = 0;

  assign word_valid = feed_on && (widx < NW);
  assign word_data  = (widx < NW) ? words[widx] : '0;
  always @(posedge clk)
    if (feed_clr) widx <= 0;
    else if (word_valid && word_ready) widx <= widx + 1;

  sd_blk_writer #(.BLOCK_BYTES(BB), .WORD_BYTES(WB), .REPLY_LIMIT(LIM)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
    .word_data(word_data), .word_valid(word_valid), .word_ready(word_ready),
    .dat0_out(dat0_out), .dat0_oe(dat0_oe), .dat0_in(dat0_in),
    .busy(busy), .done(done), .ok(ok), .crc_err(crc_err), .timeout(timeout));

  task automatic chk(input bit good, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tk(input int gap);
    repeat (gap) @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    #1;
  endtask

  function automatic logic [7:0] pat(input int kind, input int b);
    case (kind)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'(b);
      3: return 8'(b * 37 + 11) ^ 8'(b >> 3);
      default: return 8'hA5 ^ 8'(b);
    endcase
  endfunction

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic d);
    return (d ^ c[15]) ? ({c[14:0], 1'b0} ^ 16'h1021) : {c[14:0], 1'b0};
  endfunction

  task automatic frame(input int kind, input int gap, input int lead, input logic [2:0] stat,
                       input logic endb, input int bz, input int late, input bit mid);
    logic [15:0] crc;
    int errs, seen, exp_n, fi, fe, fb;
    logic expb, good, wto, bto;
    for (int w = 0; w < NW; w++)
      for (int k = 0; k < WB; k++)
        words[w][WW-1-8*k -: 8] = pat(kind, w * WB + k);
    feed_on = 1'b0; dat0_in = 1'b1;
    @(negedge clk) feed_clr = 1'b1;
    @(negedge clk) feed_clr = 1'b0; start = 1'b1;
    @(negedge clk) start = 1'b0;
    #1;
    chk(busy && !ok && !crc_err && !timeout, "R11", "busy and cleared verdict",
        {busy, ok, crc_err, timeout}, 4'b1000);
    errs = 0;
    for (int i = 0; i < late; i++) begin
      tk(gap);
      if (dat0_oe) errs++;
    end
    chk(errs == 0, "R1", "line idle while no word staged", errs, 0);
    feed_on = 1'b1;
    repeat (2) @(negedge clk);
    tk(gap);
    chk(dat0_oe && !dat0_out, "R1", "start bit", {dat0_oe, dat0_out}, 2'b10);
    crc = '0; errs = 0; fi = -1;
    for (int i = 0; i < DB; i++) begin
      if (mid && i == 40) begin
        start = 1'b1; @(negedge clk); start = 1'b0;
      end
      expb = words[i / WW][WW - 1 - (i % WW)];
      crc  = crc_step(crc, expb);
      tk(gap);
      if (!(dat0_oe && dat0_out == expb)) begin errs++; if (fi < 0) fi = i; end
    end
    chk(errs == 0, mid ? "R2/R11" : "R2", "payload bit errors (first index in actual)",
        longint'(fi), -1);
    errs = 0;
    for (int i = 15; i >= 0; i--) begin
      tk(gap);
      if (!(dat0_oe && dat0_out == crc[i])) errs++;
    end
    chk(errs == 0, "R3", "CRC bits wrong", errs, 0);
    tk(gap);
    chk(dat0_oe && dat0_out, "R4", "stop bit", {dat0_oe, dat0_out}, 2'b11);
    tk(gap); fe = dat0_oe ? 1 : 0;
    tk(gap); if (dat0_oe) fe++;
    chk(fe == 0 && !done, "R5", "line released in turnaround", fe, 0);
    fb = 1 + 3 + 1;
    good = (stat == 3'b010) && endb;
    wto = (lead >= LIM);
    bto = !wto && (bz >= LIM);
    exp_n = wto ? LIM : (bto ? lead + fb + LIM : lead + fb + bz + 1);
    seen = 0; fe = 0;
    for (int j = 1; j <= exp_n + 3 && seen == 0; j++) begin
      if (j <= lead) dat0_in = 1'b1;
      else if (j == lead + 1) dat0_in = 1'b0;
      else if (j <= lead + 4) dat0_in = stat[lead + 4 - j];
      else if (j == lead + 5) dat0_in = endb;
      else if (j <= lead + 5 + bz) dat0_in = 1'b0;
      else dat0_in = 1'b1;
      tk(gap);
      if (dat0_oe) fe++;
      if (done) seen = j;
    end
    chk(fe == 0, "R5", "line driven during reply", fe, 0);
    chk(seen == exp_n, wto || bto ? "R8" : "R7", "done strobe index", seen, exp_n);
    chk(ok == (good && !wto && !bto) && crc_err == (!wto && !good) && timeout == (wto || bto),
        wto || bto ? "R8" : "R6", "verdict {ok,crc_err,timeout}", {ok, crc_err, timeout},
        {good && !wto && !bto, !wto && !good, wto || bto});
    chk(!word_ready && widx == NW, "R10", "words taken", widx, NW);
    dat0_in = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(!done && !busy, "R7", "done is one pulse, block idle", {done, busy}, 0);
    chk(ok == (good && !wto && !bto) && timeout == (wto || bto), "R11", "verdict held",
        {ok, timeout}, {good && !wto && !bto, wto || bto});
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!dat0_oe && dat0_out && !word_ready && !busy && !done, "R11", "reset state",
        {dat0_oe, dat0_out, word_ready, busy, done}, 5'b01000);
    frame(0, 0, 0,  3'b010, 1'b1, 3,  0, 1'b0);
    frame(1, 2, 2,  3'b101, 1'b1, 0,  0, 1'b0);
    frame(2, 1, 1,  3'b010, 1'b0, 2,  0, 1'b0);
    frame(3, 0, 20, 3'b010, 1'b1, 0,  0, 1'b0);
    frame(4, 0, 0,  3'b010, 1'b1, 20, 0, 1'b0);
    frame(3, 1, 19, 3'b010, 1'b1, 19, 0, 1'b0);
    frame(2, 0, 0,  3'b010, 1'b1, 5,  4, 1'b1);
    frame(4, 2, 3,  3'b110, 1'b1, 1,  2, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule